// File: doc/BRIEF.md
# TLB Invalidation Command Controller

This block is the engine that software programs to discard cached address translations. Software uses a small register port to choose which of the two TLB banks take part, to set a first and a last address, and to issue a command. A range command walks the 4 KiB pages from the first to the last address, both included. It presents one invalidate-by-page request at a time to the TLB, and each request waits for the TLB's handshake. A full command sends a single flush-all pulse to the selected banks.

Both kinds of command set a sticky completion flag. The flag stays set until software writes zero to it. While a range walk is running, the block reports itself busy and ignores new commands. The TLB storage is not part of this block. It is reached through the request/ready handshake and the flush pulse.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset, `pgReqValid`, `flushAll`, the completion flag (offset 0x60c) and the busy bit (offset 0x610) are all 0, and the bank-select register (offset 0x5d8) reads 0.
- R2: The bank-select register at offset 0x5d8 holds two bits, and bit b enables TLB bank b. Writes to bits above bit 1 are ignored, and the register reads back zero-extended.
- R3: The first-address register (offset 0x5c4) and the last-address register (offset 0x5c8) ignore address bits [11:0] and read back with those bits zero.
- R4: Writing 0x1 to the command register (offset 0x5c0) starts a range walk. The walk issues one request per page number, ascending from the first page to the last page, both included. Each request carries `pgReqBanks` equal to the bank selection captured when the command was accepted. Later writes to the bank, first-address or last-address registers do not affect a walk that is already running.
- R5: While `pgReqValid` is high and `pgReqReady` is low, `pgReqPage` and `pgReqBanks` stay unchanged. A request is consumed only on a clock edge where both signals are high.
- R6: The completion flag at offset 0x60c reads 1 from the cycle after the last page is accepted. It stays 1 until a write of 0 to offset 0x60c, and a nonzero write there leaves it unchanged.
- R7: If the last page number is below the first page number, a range command issues no request and sets the completion flag on the next cycle.
- R8: Writing 0x2 to the command register raises `flushAll` for exactly one cycle, with `flushBanks` equal to the bank-select register, and sets the completion flag.
- R9: While a walk is running, command writes have no effect: no flush and no restart. Command values other than 0x1 and 0x2 never have an effect.
- R10: Bit 0 of offset 0x610 reads 1 exactly while a range walk is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Register write offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | 12 | Register read offset |
| rdData | output | 32 | Register read data (combinational) |
| pgReqValid | output | 1 | Page invalidate request valid |
| pgReqPage | output | 20 | Page number of the request |
| pgReqBanks | output | 2 | Banks that take the request |
| pgReqReady | input | 1 | TLB accepts the current request |
| flushAll | output | 1 | One-cycle flush-all strobe |
| flushBanks | output | 2 | Banks that take the flush-all strobe |

## Verification
The assertions check a set of rules on every cycle. A stalled request holds its page and bank mask. The current page never passes the latched last page. A running walk continues until its last handshake, and that handshake clears busy and sets the completion flag. The completion flag stays set until a zero write, and the flush strobe never lasts two cycles. Other behaviour can only be shown by the bench's scenarios, which compare against expected values. These include the exact ascending page sequence and its inclusive end under several ready patterns, and the empty-range case. They also cover the masking of the low address bits, commands ignored during a walk, and bank-mask capture while the registers change.

// File: rtl/inv_pkg.sv
package inv_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_CMD   = 12'h5c0;
  localparam logic [REG_AW-1:0] OFS_FIRST = 12'h5c4;
  localparam logic [REG_AW-1:0] OFS_LAST  = 12'h5c8;
  localparam logic [REG_AW-1:0] OFS_BANK  = 12'h5d8;
  localparam logic [REG_AW-1:0] OFS_DONE  = 12'h60c;
  localparam logic [REG_AW-1:0] OFS_STAT  = 12'h610;

  localparam logic [31:0] CMD_RANGE = 32'h1;
  localparam logic [31:0] CMD_FULL  = 32'h2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRange;  // latch first/last/banks, start walk
    logic advance;    // step to next page
    logic flushGo;    // emit flush-all strobe
  } invStrobe_t;
endpackage

// File: rtl/inv_ctrl.sv
module inv_ctrl
  import inv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              reqReady,
  input  logic              lastHit,
  input  logic              rangeEmpty,
  output invStrobe_t        strb,
  output logic              busy,
  output logic              done
);
  logic cmdWr, goRange, goFull, accept, finish, doneClr;

  assign cmdWr   = wrEn && (wrAddr == OFS_CMD);
  assign goRange = cmdWr && (wrData == CMD_RANGE) && !busy;
  assign goFull  = cmdWr && (wrData == CMD_FULL) && !busy;
  assign accept  = busy && reqReady;
  assign finish  = accept && lastHit;
  assign doneClr = wrEn && (wrAddr == OFS_DONE) && (wrData == 32'h0);

  always_comb begin
    strb.loadRange = goRange && !rangeEmpty;
    strb.advance   = accept && !lastHit;
    strb.flushGo   = goFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      if (busy) busy <= !finish;
      else      busy <= goRange && !rangeEmpty;

      if (finish || goFull || (goRange && rangeEmpty)) done <= 1'b1;
      else if (doneClr)                                 done <= 1'b0;
    end
  end

  // R6: last handshake ends the walk and raises completion
  assert_finish_sets_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqReady && lastHit) |=> (done && !busy));

  // R6: completion is sticky until a zero write
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(wrEn && wrAddr == OFS_DONE && wrData == 32'h0)) |=> done);

  // R9: a running walk is not cut short by anything but its last handshake
  assert_walk_persists_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(reqReady && lastHit)) |=> busy);
endmodule

// File: rtl/inv_datapath.sv
module inv_datapath
  import inv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BANKS      = 2,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [REG_AW-1:0] rdAddr,
  input  invStrobe_t        strb,
  input  logic              busy,
  input  logic              done,
  input  logic              reqReady,
  output logic [31:0]       rdData,
  output logic              lastHit,
  output logic              rangeEmpty,
  output logic [PAGE_W-1:0] reqPage,
  output logic [BANKS-1:0]  reqBanks,
  output logic              flushAll,
  output logic [BANKS-1:0]  flushBanks
);
  logic [BANKS-1:0]  bankSel;
  logic [PAGE_W-1:0] firstPg, lastPgReg, curPg, walkLast;
  logic [BANKS-1:0]  walkBanks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel   <= '0;
      firstPg   <= '0;
      lastPgReg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        OFS_BANK:  bankSel   <= wrData[BANKS-1:0];
        OFS_FIRST: firstPg   <= wrData[ADDR_W-1:PAGE_SHIFT];
        OFS_LAST:  lastPgReg <= wrData[ADDR_W-1:PAGE_SHIFT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPg     <= '0;
      walkLast  <= '0;
      walkBanks <= '0;
    end else if (strb.loadRange) begin
      curPg     <= firstPg;
      walkLast  <= lastPgReg;
      walkBanks <= bankSel;
    end else if (strb.advance) begin
      curPg <= curPg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushAll   <= 1'b0;
      flushBanks <= '0;
    end else begin
      flushAll <= strb.flushGo;
      if (strb.flushGo) flushBanks <= bankSel;
    end
  end

  assign rangeEmpty = lastPgReg < firstPg;
  assign lastHit    = curPg == walkLast;
  assign reqPage    = curPg;
  assign reqBanks   = walkBanks;

  always_comb begin
    case (rdAddr)
      OFS_BANK:  rdData = 32'(bankSel);
      OFS_FIRST: rdData = 32'({firstPg, {PAGE_SHIFT{1'b0}}});
      OFS_LAST:  rdData = 32'({lastPgReg, {PAGE_SHIFT{1'b0}}});
      OFS_DONE:  rdData = 32'(done);
      OFS_STAT:  rdData = 32'(busy);
      default:   rdData = 32'h0;
    endcase
  end

  // R5: a stalled request keeps its page and banks
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !reqReady) |=> ($stable(curPg) && $stable(walkBanks)));

  // R4: the walk never passes its latched last page
  assert_page_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curPg <= walkLast));

  // R8: flush strobe lasts a single cycle
  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !flushAll);
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl
  import inv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BANKS      = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [11:0]                wrAddr,
  input  logic [31:0]                wrData,
  input  logic [11:0]                rdAddr,
  output logic [31:0]                rdData,
  output logic                       pgReqValid,
  output logic [ADDR_W-PAGE_SHIFT-1:0] pgReqPage,
  output logic [BANKS-1:0]           pgReqBanks,
  input  logic                       pgReqReady,
  output logic                       flushAll,
  output logic [BANKS-1:0]           flushBanks
);
  invStrobe_t strb;
  logic busy, done, lastHit, rangeEmpty;

  inv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .reqReady(pgReqReady), .lastHit(lastHit), .rangeEmpty(rangeEmpty),
    .strb(strb), .busy(busy), .done(done)
  );

  inv_datapath #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .BANKS(BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .strb(strb), .busy(busy), .done(done),
    .reqReady(pgReqReady), .rdData(rdData), .lastHit(lastHit),
    .rangeEmpty(rangeEmpty), .reqPage(pgReqPage), .reqBanks(pgReqBanks),
    .flushAll(flushAll), .flushBanks(flushBanks)
  );

  assign pgReqValid = busy;
endmodule

// File: tb/tb_tlb_inval_ctrl.sv
module tb_tlb_inval_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;

  localparam logic [31:0] V_FIRST[NV] = '{32'h0000_1000, 32'h1234_5ABC, 32'h0000_8000, 32'hFFFF_D000, 32'h0010_0000};
  localparam logic [31:0] V_LAST [NV] = '{32'h0000_3FFF, 32'h1234_5000, 32'h0000_4000, 32'hFFFF_FFFF, 32'h0010_7FFF};
  localparam logic [1:0]  V_BANK [NV] = '{2'b11, 2'b01, 2'b10, 2'b10, 2'b11};
  localparam int          V_MODE [NV] = '{0, 1, 0, 2, 1};

  logic clk = 0, rstN = 0, wrEn = 0, pgReqReady = 0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic pgReqValid, flushAll;
  logic [19:0] pgReqPage;
  logic [1:0] pgReqBanks, flushBanks;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_inval_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pgReqValid(pgReqValid),
    .pgReqPage(pgReqPage), .pgReqBanks(pgReqBanks), .pgReqReady(pgReqReady),
    .flushAll(flushAll), .flushBanks(flushBanks)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  // Consume a walk; called right after the command write returns.
  task automatic collect(input logic [19:0] expFirst, input int expCount,
                         input logic [1:0] expBanks, input int mode, input string tag);
    logic [19:0] expPg = expFirst;
    int got = 0;
    bit ok = 1;
    logic [31:0] rv;
    for (int i = 0; i < 200; i++) begin
      pgReqReady = (mode == 0) ? 1'b1 : (mode == 1) ? i[0] : ((i % 3) == 2);
      #1;
      if (!pgReqValid) break;
      if (pgReqPage != expPg || pgReqBanks != expBanks) begin
        ok = 0;
        $display("FAIL %s page=0x%0h banks=%0d expected page=0x%0h banks=%0d",
                 tag, pgReqPage, pgReqBanks, expPg, expBanks);
      end
      if (pgReqReady) begin expPg++; got++; end
      @(negedge clk);
    end
    pgReqReady = 0;
    nChecks++; if (!ok) nFail++;
    check(got == expCount, {tag, " count"}, got, expCount);
    readReg(12'h60c, rv);
    check(rv == 1, {tag, " done R6"}, rv, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!pgReqValid && !flushAll, "R1 outputs idle", {pgReqValid, flushAll}, 0);
    readReg(12'h60c, rv); check(rv == 0, "R1 done", rv, 0);
    readReg(12'h5d8, rv); check(rv == 0, "R1 bank select", rv, 0);
    rstN = 1;
    @(negedge clk);
    readReg(12'h610, rv); check(rv == 0, "R1 busy", rv, 0);

    // R2 bank select masking
    writeReg(12'h5d8, 32'hFF);
    readReg(12'h5d8, rv); check(rv == 3, "R2 bank readback", rv, 3);
    // R3 low bits ignored
    writeReg(12'h5c4, 32'h1234_5ABC);
    readReg(12'h5c4, rv); check(rv == 32'h1234_5000, "R3 first readback", rv, 32'h1234_5000);
    writeReg(12'h5c8, 32'hABCD_EFFF);
    readReg(12'h5c8, rv); check(rv == 32'hABCD_E000, "R3 last readback", rv, 32'hABCD_E000);

    // Vector table: R4 walks, R5 stalls, R7 empty range
    for (int v = 0; v < NV; v++) begin
      int cnt;
      cnt = (V_LAST[v][31:12] >= V_FIRST[v][31:12]) ? int'(V_LAST[v][31:12] - V_FIRST[v][31:12]) + 1 : 0;
      writeReg(12'h5d8, 32'(V_BANK[v]));
      writeReg(12'h5c4, V_FIRST[v]);
      writeReg(12'h5c8, V_LAST[v]);
      writeReg(12'h5c0, 32'h1);
      collect(V_FIRST[v][31:12], cnt, V_BANK[v], V_MODE[v],
              (cnt == 0) ? "R7 empty range" : "R4 R5 walk");
      writeReg(12'h60c, 32'h0);
      readReg(12'h60c, rv); check(rv == 0, "R6 zero write clears", rv, 0);
    end

    // R9/R10: commands ignored during a walk; banks latched (R4)
    writeReg(12'h5d8, 32'h1);
    writeReg(12'h5c4, 32'h5000);
    writeReg(12'h5c8, 32'h6000);
    writeReg(12'h5c0, 32'h1);
    readReg(12'h610, rv); check(rv == 1, "R10 busy during walk", rv, 1);
    writeReg(12'h5d8, 32'h2);
    writeReg(12'h5c0, 32'h2);
    check(!flushAll, "R9 full ignored while busy", flushAll, 0);
    writeReg(12'h5c4, 32'h9000);
    writeReg(12'h5c0, 32'h1);
    check(pgReqPage == 20'h5 && pgReqBanks == 2'b01, "R5 held request",
          {pgReqPage, 10'b0, pgReqBanks}, {20'h5, 10'b0, 2'b01});
    collect(20'h5, 2, 2'b01, 0, "R9 walk unaffected");
    readReg(12'h610, rv); check(rv == 0, "R10 busy cleared", rv, 0);
    writeReg(12'h60c, 32'h0);

    // R8 full invalidate
    writeReg(12'h5d8, 32'h3);
    writeReg(12'h5c0, 32'h2);
    check(flushAll && flushBanks == 2'b11, "R8 flush strobe", {flushAll, flushBanks}, 3'b111);
    readReg(12'h60c, rv); check(rv == 1, "R8 done set", rv, 1);
    @(negedge clk);
    check(!flushAll, "R8 single cycle", flushAll, 0);
    writeReg(12'h60c, 32'h5);
    readReg(12'h60c, rv); check(rv == 1, "R6 nonzero write ignored", rv, 1);
    writeReg(12'h60c, 32'h0);
    readReg(12'h60c, rv); check(rv == 0, "R6 cleared", rv, 0);

    // R9 unknown command value
    writeReg(12'h5c0, 32'h3);
    check(!flushAll && !pgReqValid, "R9 bad command no action", {flushAll, pgReqValid}, 0);
    readReg(12'h60c, rv); check(rv == 0, "R9 bad command no done", rv, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule